// File: doc/BRIEF.md
# Serial Receiver With Packed Status Word

This block is the receive half of an asynchronous serial port. It watches a single line that rests high. A falling edge starts a frame. The block confirms the start bit half a bit period later, then samples each later bit at its centre. The bits land in a receive shift register, least significant bit first. When the shift register holds a whole frame, the frame is copied into a receive buffer, and the buffer-full request is raised.

The bit period is set by a programmable clock divisor, which it shares with the transmitter. A static select picks one of two frame formats:
- **Short:** eight data bits and one stop bit.
- **Long:** nine data bits and one stop bit.

The sixteen-bit status word packs the following fields together:
- the buffered frame;
- the buffer-full request;
- an overrun flag;
- two transmitter flags, taken in as plain inputs;
- the synchronised level of the line, so software can test it bit by bit.

The status word is a register view and is always valid, so there is no handshake. The line cannot be stalled, which means the block offers no back-pressure. If software has not cleared the buffer-full request before the next frame completes, the new frame still replaces the buffer and the overrun flag records that a frame was lost.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status word reads with overrun (bit 15) and buffer-full (bit 14) at 0, bits 9..0 at 0, and `rbf_irq` low.
- R2: In short mode (`long_mode`=0) a frame is a start bit (0), eight data bits least significant first, and one stop bit. After it, bits 7..0 hold the data, and bits 9 and 8 both hold the sampled stop level.
- R3: In long mode (`long_mode`=1) a frame carries nine data bits least significant first, then a stop bit. After it, bits 8..0 hold the data and bit 9 holds the sampled stop level.
- R4: Completing a frame sets the buffer-full request, which is visible both on `rbf_irq` and on bit 14.
- R5: If a frame completes while buffer-full is still set, bit 15 (overrun) becomes 1 and the buffer takes the new frame.
- R6: A one-cycle pulse on `rbf_clr` clears both buffer-full and overrun, and leaves the buffered data unchanged. If a frame completes in the same cycle, the load wins for buffer-full.
- R7: Bit 13 mirrors `tbe_in`, bit 12 mirrors `tsre_in`, and bit 10 always reads 0.
- R8: Bit 11 equals the level of `rx_pin` two clock cycles earlier, through a two-flop synchroniser.
- R9: A low pulse on an idle line that is gone when the half-bit check samples it is rejected. No frame is loaded, buffer-full stays 0, and the buffer is unchanged.
- R10: The bit period is `divisor` clock cycles (any value of 4 or more). The start bit is re-checked `divisor/2` cycles after the falling edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pin | input | 1 | Asynchronous serial line, idle high |
| divisor | input | DIV_W | Clock cycles per bit (at least 4) |
| long_mode | input | 1 | 1 selects nine data bits, 0 selects eight |
| tbe_in | input | 1 | Transmit buffer empty request, mirrored into bit 13 |
| tsre_in | input | 1 | Transmit shift register empty, mirrored into bit 12 |
| rbf_clr | input | 1 | Pulse that clears buffer-full and overrun |
| status_word | output | 16 | Packed data, stop bits and flags |
| rbf_irq | output | 1 | Receive buffer full request |

## Verification
Every 8-bit value is sent in short mode and every 9-bit value in long mode. Each run uses a different divisor. Together these show bit order, the position of each data bit, and where bit 8 is taken from in each mode. The stop level is forced low on a regular subset of frames, which separates the stop-bit fields from the data fields. Back-to-back frames with no clear in between exercise overrun and overwrite. A short glitch tests start-bit rejection, and toggling the line and the transmitter flags tests the mirror bits.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int FRAME_W = 10;
  localparam int WORD_W  = 16;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA} rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  output logic rx_s
);
  logic meta;
  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= 1'b1;
      rx_s <= 1'b1;
      warm <= '0;
    end else begin
      meta <= rx_pin;
      rx_s <= meta;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  // R8: synchronised level is the pin two cycles back
  assert_pin_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (rx_s == $past(rx_pin, 2)));
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_s,
  input  logic [DIV_W-1:0]   divisor,
  input  logic               long_mode,
  output logic               done,
  output logic [FRAME_W-1:0] frame
);
  localparam int IDX_W = $clog2(FRAME_W + 1);

  rx_state_e          state;
  logic               rx_prev;
  logic [DIV_W-1:0]   cnt;
  logic [IDX_W-1:0]   bitidx;
  logic [IDX_W-1:0]   last_idx;
  logic [FRAME_W-1:0] sr;
  logic [DIV_W-1:0]   half_m1;

  assign last_idx = long_mode ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
  assign half_m1  = (divisor >> 1) - DIV_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rx_prev <= 1'b1;
      cnt     <= '0;
      bitidx  <= '0;
      sr      <= '0;
      done    <= 1'b0;
    end else begin
      rx_prev <= rx_s;
      done    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (rx_prev && !rx_s) begin
            state <= ST_START;
            cnt   <= half_m1;
          end
        end
        ST_START: begin
          if (cnt != '0) cnt <= cnt - DIV_W'(1);
          else if (!rx_s) begin
            state  <= ST_DATA;
            cnt    <= divisor - DIV_W'(1);
            bitidx <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_DATA: begin
          if (cnt != '0) cnt <= cnt - DIV_W'(1);
          else begin
            sr <= {rx_s, sr[FRAME_W-1:1]};
            if (bitidx == last_idx) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              bitidx <= bitidx + IDX_W'(1);
              cnt    <= divisor - DIV_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Short frames sit in the top nine bits; stop is copied into bit 8.
  assign frame = long_mode ? sr : {sr[FRAME_W-1], sr[FRAME_W-1:1]};

  // R3: bit counter never runs past the selected frame length
  assert_bit_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (bitidx <= last_idx));
  // R4: completion is a single-cycle event
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: a start check that sees a high line returns to idle without loading
  assert_glitch_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && cnt == '0 && rx_s) |=> (state == ST_IDLE && !done));
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               rbf_clr,
  output logic [FRAME_W-1:0] rx_buf,
  output logic               rbf,
  output logic               ovr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_buf <= '0;
      rbf    <= 1'b0;
      ovr    <= 1'b0;
    end else begin
      if (load) rx_buf <= frame;
      if (load) rbf <= 1'b1;
      else if (rbf_clr) rbf <= 1'b0;
      if (rbf_clr) ovr <= 1'b0;
      else if (load && rbf) ovr <= 1'b1;
    end
  end

  assert_load_sets_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> rbf);
  assert_overrun_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && rbf && !rbf_clr) |=> ovr);
  assert_overrun_needs_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> rbf);
  assert_clear_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rbf_clr && !load) |=> (!rbf && !ovr && $stable(rx_buf)));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pin,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              long_mode,
  input  logic              tbe_in,
  input  logic              tsre_in,
  input  logic              rbf_clr,
  output logic [WORD_W-1:0] status_word,
  output logic              rbf_irq
);
  logic               rx_s;
  logic               done;
  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] rx_buf;
  logic               rbf;
  logic               ovr;

  uart_rx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .rx_s(rx_s)
  );

  uart_rx_engine #(.DIV_W(DIV_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .divisor(divisor),
    .long_mode(long_mode), .done(done), .frame(frame)
  );

  uart_rx_buffer u_buffer (
    .clk(clk), .rst_n(rst_n), .load(done), .frame(frame),
    .rbf_clr(rbf_clr), .rx_buf(rx_buf), .rbf(rbf), .ovr(ovr)
  );

  assign status_word = {ovr, rbf, tbe_in, tsre_in, rx_s, 1'b0, rx_buf};
  assign rbf_irq     = rbf;

  // R7: the transmitter mirrors track their inputs in the same cycle
  assert_tx_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[13] == tbe_in) && (status_word[12] == tsre_in));
endmodule

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_pin = 1'b1;
  logic [15:0] divisor = 16'd8;
  logic        long_mode = 1'b0;
  logic        tbe_in = 1'b1;
  logic        tsre_in = 1'b0;
  logic        rbf_clr = 1'b0;
  logic [15:0] status_word;
  logic        rbf_irq;

  int vectors = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_rx_status #(.DIV_W(16)) u_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .divisor(divisor),
    .long_mode(long_mode), .tbe_in(tbe_in), .tsre_in(tsre_in),
    .rbf_clr(rbf_clr), .status_word(status_word), .rbf_irq(rbf_irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [8:0] data, input logic stop, input int nbits);
    rx_pin = 1'b0; tick(int'(divisor));
    for (int i = 0; i < nbits; i++) begin
      rx_pin = data[i]; tick(int'(divisor));
    end
    rx_pin = stop; tick(int'(divisor));
    rx_pin = 1'b1; tick(4);
  endtask

  task automatic clear();
    rbf_clr = 1'b1; tick(1); rbf_clr = 1'b0; tick(1);
  endtask

  function automatic logic [15:0] expw(input logic ov, input logic fl, input logic rx,
                                       input logic [9:0] bufv);
    return {ov, fl, tbe_in, tsre_in, rx, 1'b0, bufv};
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [9:0] last_buf;
    tick(3); rst_n = 1'b1; tick(4);
    @(negedge clk);
    check("R1 reset word", status_word, expw(1'b0, 1'b0, 1'b1, 10'd0));
    check("R1 reset irq", {15'd0, rbf_irq}, 16'd0);

    // R7 and R8: mirrors
    tbe_in = 1'b0; tsre_in = 1'b1; rx_pin = 1'b1; tick(1);
    @(negedge clk);
    check("R7 tx mirrors", status_word, expw(1'b0, 1'b0, 1'b1, 10'd0));
    tbe_in = 1'b1; tsre_in = 1'b0;
    @(posedge clk); #1;
    rx_pin = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 pin after one edge", {15'd0, status_word[11]}, 16'd1);
    @(negedge clk);
    check("R8 pin after two edges", {15'd0, status_word[11]}, 16'd0);
    rx_pin = 1'b1; tick(3 * int'(divisor));

    // R9: glitch shorter than half bit, with divisor 16
    divisor = 16'd16;
    rx_pin = 1'b0; tick(2); rx_pin = 1'b1; tick(40);
    @(negedge clk);
    check("R9 glitch rejected", status_word, expw(1'b0, 1'b0, 1'b1, 10'd0));

    // R2/R10/R11: every byte in short mode at divisor 8
    divisor = 16'd8; long_mode = 1'b0;
    for (int v = 0; v < 256; v++) begin
      logic st;
      st = (v % 7) != 3;
      send(9'(v), st, 8);
      @(negedge clk);
      check("R2 short frame", status_word, expw(1'b0, 1'b1, 1'b1, {st, st, 8'(v)}));
      check("R4 irq raised", {15'd0, rbf_irq}, 16'd1);
      clear();
    end

    // R3/R10: every nine-bit value in long mode at divisor 5
    divisor = 16'd5; long_mode = 1'b1;
    for (int v = 0; v < 512; v++) begin
      logic st;
      st = (v % 5) != 2;
      send(9'(v), st, 9);
      @(negedge clk);
      check("R3 long frame", status_word, expw(1'b0, 1'b1, 1'b1, {st, 9'(v)}));
      clear();
    end

    // R6: clear leaves data, drops flags
    @(negedge clk);
    check("R6 clear keeps data", status_word, expw(1'b0, 1'b0, 1'b1, {1'b1, 9'd511}));

    // R5: overrun and overwrite, then R6 clear
    divisor = 16'd6; long_mode = 1'b0;
    send(9'h0A5, 1'b1, 8);
    send(9'h03C, 1'b1, 8);
    @(negedge clk);
    check("R5 overrun overwrite", status_word, expw(1'b1, 1'b1, 1'b1, {2'b11, 8'h3C}));
    last_buf = {2'b11, 8'h3C};
    clear();
    @(negedge clk);
    check("R6 clears overrun", status_word, expw(1'b0, 1'b0, 1'b1, last_buf));
    check("R6 irq low", {15'd0, rbf_irq}, 16'd0);

    // R9: glitch after data, buffer kept
    divisor = 16'd16;
    rx_pin = 1'b0; tick(3); rx_pin = 1'b1; tick(40);
    @(negedge clk);
    check("R9 buffer kept", status_word, expw(1'b0, 1'b0, 1'b1, last_buf));

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule